// File: doc/BRIEF.md
# Synchronous Flash Burst Read Sequencer

This block models the device side of a clocked burst read port on a NOR-style memory array. A host first writes a 16-bit configuration word. That word chooses whether burst reads are enabled, the burst length, the first-access latency, how many clocks each beat is held, and whether the data bus is 16 or 32 bits wide. After burst reads are enabled, an address strobe captures a start address. The block then counts out the configured latency and streams data beats in linear order.

When the last beat of the burst has been delivered, the block wraps back to the burst's own starting address and continues for as long as the clock runs. During every clock of that final beat it drives an active-low indicator, which tells the host to issue a new strobe. A new strobe, or any configuration write, abandons the current burst at once. The array contents come from a small computed ROM.

Top module: `flash_burst_seq`

## Requirements
- R1: After reset the configuration word is 0, so burst reads are disabled. `data_vld_o` is 0, `data_o` is 0, `ind_en_o` is 0 and `ind_n_o` is 1.
- R2: A strobe on `adv_i` has no effect while the burst enable bit is 0. `data_vld_o` stays 0.
- R3: The configuration word layout is: bit 0 burst enable; bits 2:1 length code (0, 1, 2, 3 select 4, 8, 16, 32 words of 16 bits); bits 6:3 latency field F; bit 7 selects a hold of 2 clocks (0 selects 1 clock); bit 8 selects the 16-bit bus (0 selects the 32-bit bus). Other bits are ignored. A write takes effect at the clock edge where `cfg_we_i` is sampled.
- R4: With latency L = F + 2 (F above 14 acts as 14, so L runs from 2 to 16), the first beat is sampled by the host at the L-th rising edge after the strobe edge. `data_vld_o` is 0 before that.
- R5: On the 32-bit bus a burst has words/2 beats. Beat i carries word start+2i in bits 15:0 and word start+2i+1 in bits 31:16. Addresses are taken modulo 2^AW.
- R6: On the 16-bit bus a burst has as many beats as words. Beat i carries word start+i in bits 15:0, and bits 31:16 are 0.
- R7: Each beat stays on `data_o` for exactly 1 or 2 clocks, as the hold bit selects.
- R8: `ind_en_o` is 1 and `ind_n_o` is 0 during every clock of the final beat of the burst. At all other times `ind_en_o` is 0 and `ind_n_o` is 1.
- R9: After the final beat, the next beat is beat 0 at the burst's starting address, and the sequence repeats.
- R10: A strobe while burst reads are enabled captures the new address and restarts the latency count, even in the middle of a burst.
- R11: A configuration write ends any burst. `data_vld_o` is 0 from the following cycle until the next strobe.
- R12: The word at address a is {a[7:0] XOR 8'hA5, a[7:0]}. `data_o` is 0 whenever `data_vld_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_wdata_i | input | 16 | Configuration write data |
| adv_i | input | 1 | Address strobe, active high |
| addr_i | input | AW | Start word address |
| data_o | output | 32 | Beat data |
| data_vld_o | output | 1 | Beat data valid |
| ind_n_o | output | 1 | Final-beat indicator, active low |
| ind_en_o | output | 1 | Indicator drive enable (0 means released) |

## Verification
The assertions assume that the configuration word changes only through a write, and that every write is treated as an abort. They also assume that beats at different addresses carry different values. This holds because the low address byte appears in the data and bursts are at most 32 words long. The stimulus sets up every burst with a write followed by a strobe. Inputs change half a period away from the sampling edge. Configuration is never changed while a burst runs except through the write being tested, and start addresses include one that crosses the top of the address space.

// File: rtl/flash_burst_pkg.sv
package flash_burst_pkg;
  parameter int unsigned CFG_W = 16;
  parameter int unsigned BEAT_W = 6;
  parameter int unsigned LAT_MAX_F = 14;

  typedef struct packed {
    logic [6:0] rsvd;
    logic       bus16;
    logic       hold2;
    logic [3:0] lat;
    logic [1:0] len;
    logic       en;
  } burst_cfg_t;

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_DATA} seq_state_e;

  function automatic logic [BEAT_W-1:0] beats_of(burst_cfg_t c);
    logic [BEAT_W-1:0] words;
    words = BEAT_W'(4) << c.len;
    return c.bus16 ? words : (words >> 1);
  endfunction
endpackage

// File: rtl/flash_cfg_reg.sv
module flash_cfg_reg
  import flash_burst_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CFG_W-1:0] wdata_i,
  output burst_cfg_t       cfg_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_o <= '0;
    else if (we_i) cfg_o <= burst_cfg_t'(wdata_i);
  end
endmodule

// File: rtl/flash_word_rom.sv
module flash_word_rom #(
  parameter int unsigned AW = 16,
  parameter int unsigned WORD_W = 16
) (
  input  logic [AW-1:0]     addr_i,
  output logic [WORD_W-1:0] word_o
);
  localparam int unsigned HALF_W = WORD_W / 2;
  // stand-in array content: low byte of address, and its XOR with 0xA5
  always_comb word_o = {addr_i[HALF_W-1:0] ^ HALF_W'(8'hA5), addr_i[HALF_W-1:0]};
endmodule

// File: rtl/flash_beat_ctrl.sv
module flash_beat_ctrl
  import flash_burst_pkg::*;
#(
  parameter int unsigned AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  burst_cfg_t    cfg_i,
  input  logic          cfg_we_i,
  input  logic          adv_i,
  input  logic [AW-1:0] addr_i,
  output logic          valid_o,
  output logic          last_o,
  output logic [AW-1:0] beat_addr_o
);
  localparam int unsigned CNT_W = 5;

  seq_state_e        state_q;
  logic [CNT_W-1:0]  lat_cnt_q;
  logic              hold_q;
  logic [BEAT_W-1:0] beat_q;
  logic [AW-1:0]     start_q;
  logic [BEAT_W-1:0] beats;
  logic [3:0]        lat_f;

  always_comb begin
    beats = beats_of(cfg_i);
    lat_f = (cfg_i.lat > 4'(LAT_MAX_F)) ? 4'(LAT_MAX_F) : cfg_i.lat;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      lat_cnt_q <= '0;
      hold_q    <= 1'b0;
      beat_q    <= '0;
      start_q   <= '0;
    end else if (cfg_we_i) begin
      state_q <= ST_IDLE;
    end else if (adv_i && cfg_i.en) begin
      start_q   <= addr_i;
      lat_cnt_q <= {1'b0, lat_f} + CNT_W'(1);
      hold_q    <= 1'b0;
      beat_q    <= '0;
      state_q   <= ST_WAIT;
    end else begin
      unique case (state_q)
        ST_WAIT: begin
          if (lat_cnt_q == CNT_W'(1)) state_q <= ST_DATA;
          else lat_cnt_q <= lat_cnt_q - CNT_W'(1);
        end
        ST_DATA: begin
          if (cfg_i.hold2 && !hold_q) begin
            hold_q <= 1'b1;
          end else begin
            hold_q <= 1'b0;
            beat_q <= (beat_q == beats - BEAT_W'(1)) ? '0 : beat_q + BEAT_W'(1);
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    valid_o     = (state_q == ST_DATA);
    last_o      = valid_o && (beat_q == beats - BEAT_W'(1));
    beat_addr_o = start_q + (cfg_i.bus16 ? AW'(beat_q) : AW'({beat_q, 1'b0}));
  end
endmodule

// File: rtl/flash_burst_seq.sv
module flash_burst_seq
  import flash_burst_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned WORD_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cfg_we_i,
  input  logic [CFG_W-1:0]    cfg_wdata_i,
  input  logic                adv_i,
  input  logic [AW-1:0]       addr_i,
  output logic [2*WORD_W-1:0] data_o,
  output logic                data_vld_o,
  output logic                ind_n_o,
  output logic                ind_en_o
);
  localparam int unsigned LANES = 2;

  burst_cfg_t             cfg_q;
  logic                   vld;
  logic                   last;
  logic [AW-1:0]          beat_addr;
  logic [WORD_W-1:0]      lane_word [LANES];

  flash_cfg_reg i_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .wdata_i (cfg_wdata_i),
    .cfg_o   (cfg_q)
  );

  flash_beat_ctrl #(.AW(AW)) i_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_i       (cfg_q),
    .cfg_we_i    (cfg_we_i),
    .adv_i       (adv_i),
    .addr_i      (addr_i),
    .valid_o     (vld),
    .last_o      (last),
    .beat_addr_o (beat_addr)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    flash_word_rom #(.AW(AW), .WORD_W(WORD_W)) i_rom (
      .addr_i (beat_addr + AW'(g)),
      .word_o (lane_word[g])
    );
  end

  always_comb begin
    data_vld_o = vld;
    data_o     = '0;
    if (vld) begin
      data_o[WORD_W-1:0] = lane_word[0];
      if (!cfg_q.bus16) data_o[2*WORD_W-1:WORD_W] = lane_word[1];
    end
    ind_en_o = last;
    ind_n_o  = ~last;
  end
endmodule

// File: rtl/flash_burst_seq_chk.sv
module flash_burst_seq_chk
  import flash_burst_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cfg_we_i,
  input logic          adv_i,
  input logic [DW-1:0] data_o,
  input logic          data_vld_o,
  input logic          ind_n_o,
  input logic          ind_en_o,
  input burst_cfg_t    cfg_q
);
  p_ind_in_burst_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ind_en_o |-> (data_vld_o && !ind_n_o));

  p_ind_released_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ind_en_o |-> ind_n_o);

  p_disabled_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_q.en |-> !data_vld_o);

  p_restart_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && cfg_q.en && !cfg_we_i) |=> !data_vld_o);

  p_write_abort_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> !data_vld_o);

  p_zero_idle_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_vld_o |-> (data_o == '0));

  p_hold_pair_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q.hold2 && data_vld_o && $past(data_vld_o) && (data_o != $past(data_o))
     && !adv_i && !cfg_we_i) |=> (data_o == $past(data_o)));
endmodule

bind flash_burst_seq flash_burst_seq_chk #(.DW(2*WORD_W)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cfg_we_i   (cfg_we_i),
  .adv_i      (adv_i),
  .data_o     (data_o),
  .data_vld_o (data_vld_o),
  .ind_n_o    (ind_n_o),
  .ind_en_o   (ind_en_o),
  .cfg_q      (cfg_q)
);

// File: tb/test_flash_burst_seq.sv
`timescale 1ns/1ps
module test_flash_burst_seq;
  localparam int unsigned AW = 16;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [15:0] cfg_wdata_i = '0;
  logic        adv_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [31:0] data_o;
  logic        data_vld_o, ind_n_o, ind_en_o;

  int n_chk = 0;
  int n_bad = 0;

  typedef struct {
    logic        vld;
    logic [31:0] data;
    logic        ind;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #4 clk_i = ~clk_i;

  flash_burst_seq #(.AW(AW)) i_flash_burst_seq (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_wdata_i, .adv_i, .addr_i,
    .data_o, .data_vld_o, .ind_n_o, .ind_en_o
  );

  // R3 layout: en[0], len[2:1], lat[6:3], hold2[7], bus16[8]
  function automatic logic [15:0] mk_cfg(bit en, int len, int lat, bit hold2, bit bus16);
    return {7'b0, bus16, hold2, 4'(lat - 2), 2'(len), en};
  endfunction

  // R12 content model
  function automatic logic [15:0] word_at(logic [AW-1:0] a);
    return {a[7:0] ^ 8'hA5, a[7:0]};
  endfunction

  function automatic void check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endfunction

  // monitor: samples 3 ns after each rising edge
  initial begin
    forever begin
      @(posedge clk_i);
      #3;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        check({e.tag, " vld"}, 32'(data_vld_o), 32'(e.vld));
        check({e.tag, " data"}, data_o, e.data);
        check("R8 ind_en", 32'(ind_en_o), 32'(e.ind));
        check("R8 ind_n", 32'(ind_n_o), 32'(!e.ind));
      end
    end
  end

  task automatic push_idle(int n, string tag);
    for (int i = 0; i < n; i++) sb.push_back('{1'b0, 32'h0, 1'b0, tag});
  endtask

  task automatic wait_drain();
    while (sb.size() > 0) @(negedge clk_i);
  endtask

  task automatic write_cfg(logic [15:0] w);
    @(negedge clk_i);
    cfg_we_i = 1'b1;
    cfg_wdata_i = w;
    push_idle(1, "R11");
    @(negedge clk_i);
    cfg_we_i = 1'b0;
    wait_drain();
  endtask

  // strobe and predict ncyc cycles of output
  task automatic strobe(logic [AW-1:0] a, int len, int lat, bit hold2, bit bus16,
                        int ncyc, string tag);
    int words, beats, hold;
    words = 4 << len;
    beats = bus16 ? words : words / 2;
    hold  = hold2 ? 2 : 1;
    @(negedge clk_i);
    adv_i = 1'b1;
    addr_i = a;
    for (int m = 0; m < ncyc; m++) begin
      if (m < lat - 1) begin
        sb.push_back('{1'b0, 32'h0, 1'b0, "R4"});
      end else begin
        int b;
        logic [AW-1:0] wa;
        logic [31:0] d;
        b = ((m - (lat - 1)) / hold) % beats;
        wa = bus16 ? a + AW'(b) : a + AW'(2 * b);
        d = bus16 ? {16'h0, word_at(wa)} : {word_at(wa + AW'(1)), word_at(wa)};
        sb.push_back('{1'b1, d, b == beats - 1, tag});
      end
    end
    @(posedge clk_i);
    @(negedge clk_i);
    adv_i = 1'b0;
    repeat (ncyc - 1) @(negedge clk_i);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check("R1 vld", 32'(data_vld_o), 32'h0);
    check("R1 data", data_o, 32'h0);
    check("R1 ind_en", 32'(ind_en_o), 32'h0);
    check("R1 ind_n", 32'(ind_n_o), 32'h1);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    // R2 strobe ignored with burst disabled
    @(negedge clk_i);
    adv_i = 1'b1;
    addr_i = 16'h0040;
    push_idle(8, "R2");
    @(negedge clk_i);
    adv_i = 1'b0;
    wait_drain();

    // R5 32-bit, 8 words, L=2, hold 1, R9 wrap
    write_cfg(mk_cfg(1, 1, 2, 0, 0));
    strobe(16'h0010, 1, 2, 0, 0, 1 + 4 * 3, "R5 R9 R12");

    // R5 32-bit, 32 words, L=16, hold 2, crosses top of address space
    write_cfg(mk_cfg(1, 3, 16, 1, 0));
    strobe(16'hFFF0, 3, 16, 1, 0, 15 + 32 * 2 + 6, "R5 R7 R9");

    // R6 16-bit, 4 words, L=5, hold 2
    write_cfg(mk_cfg(1, 0, 5, 1, 1));
    strobe(16'h0123, 0, 5, 1, 1, 4 + 8 * 3, "R6 R7");

    // R10 restrobe mid-burst, 16-bit, 16 words, L=3
    write_cfg(mk_cfg(1, 2, 3, 0, 1));
    strobe(16'h0200, 2, 3, 0, 1, 2 + 9, "R6");
    strobe(16'h0A7C, 2, 3, 0, 1, 2 + 20, "R10 R9");

    // R11 write aborts running burst
    write_cfg(mk_cfg(1, 2, 3, 0, 1));
    push_idle(4, "R11");
    wait_drain();

    // R6 16-bit, 32 words, L=7, hold 1, with wrap
    write_cfg(mk_cfg(1, 3, 7, 0, 1));
    strobe(16'h8000, 3, 7, 0, 1, 6 + 40, "R6 R9 R4");
    write_cfg(16'h0000);
    repeat (2) @(negedge clk_i);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule